// File: doc/BRIEF.md
# Two-Channel Programmable PWM Timer

This block is a 16-bit counter that drives two pulse-width-modulated outputs. Software programs it through a write-only register port. The registers hold a period, four compare values, a repetition count, a control word and one event-select word per output. Each output is raised and lowered by the events it selects: the end of the period, or a match of the counter against one of the compare values. Each output is registered and can then be inverted on its own.

The counter follows four named states. IDLE holds the count at 0 and is left once the run bit is set. From IDLE, continuous mode goes to UP and either single-shot mode goes to WAIT. WAIT holds the count at 0 until the trigger input pulses, then goes to UP. UP counts upward. At the period it either wraps to 0 and stays in UP (continuous), wraps to 0 and goes to WAIT (single-shot), or turns to DOWN (up-down counting). DOWN counts toward 0 and then goes back to UP, or to WAIT in single-shot mode. A retriggerable trigger sends UP or DOWN back to UP at count 0. Clearing the run bit sends any state to IDLE.

The period and compare registers can be double-buffered. Interleaved modes replace the low compare values with fixed fractions of the period. Push-pull mode steers one waveform to the two outputs in alternate periods. A repetition divider sets the rate of an interrupt pulse.

Top module: `pwm_timer`

## Requirements
- R1: After the synchronous reset, and whenever control bit 0 (run) is 0, the counter holds at 0. Both outputs then sit at their inactive level, and neither the wrap strobe nor the interrupt ever pulses.
- R2: In up counting (control bit 1 = 0) with run set and continuous mode (control bits 3:2 = 00), the counter goes 0, 1, up to the period (address 1), then 0 again. `roll_evt` pulses once every period+1 cycles.
- R3: The event-select word (address 7 for output A, address 8 for output B) holds a set mask in bits 4:0 and a clear mask in bits 12:8. Event index 0 is the counter at the period value while counting up. Indices 1 to 4 are the counter equal to compare 1 to 4 (addresses 2 to 5). The output register becomes 1 on a selected set event and 0 on a selected clear event, and clear wins when both occur in the same cycle.
- R4: In up-down counting (control bit 1 = 1) the counter climbs to the period and then descends to 1, so one cycle lasts 2 x period clocks. While descending, the set mask clears the output and the clear mask sets it.
- R5: In single-shot non-retriggerable mode (control bits 3:2 = 10) the counter waits at 0 for a trigger pulse and then runs exactly one period. Triggers that arrive while it runs have no effect.
- R6: In single-shot retriggerable mode (control bits 3:2 = 01), a trigger while running restarts the count from 0.
- R7: With push-pull (control bit 4) set, output A carries the output-A waveform in one period and output B carries it in the next. The output that is not carrying the waveform is held inactive.
- R8: Control bits 5 and 6 make output A and output B active-low, each on its own.
- R9: `rep_irq` pulses together with `roll_evt`: on the first wrap after starting, then on every (R+1)-th wrap, where R is the repetition value at address 6.
- R10: With shadowing enabled (control bit 9), writes to the period and compare registers take effect only when the counter wraps or restarts. If control bit 10 is also set, a wrap copies the written values only when it raises `rep_irq`.
- R11: Control bits 8:7 select interleaving: 01 forces compare 1 to P/2; 10 forces compares 1 and 2 to P/3 and 2P/3; 11 forces compares 1 to 3 to P/4, P/2 and 3P/4. The forced values follow the active period, and the stored compare values are kept unchanged.
- R12: A control write that sets up-down counting together with a non-zero interleave field is discarded and raises `cfg_err`. The next accepted control write clears `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0 control, 1 period, 2-5 compares, 6 repetition, 7-8 event selects) |
| wr_data | input | 16 | Write data |
| trig | input | 1 | Start/restart trigger for the single-shot modes |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| rep_irq | output | 1 | Repetition interrupt pulse |
| roll_evt | output | 1 | Wrap strobe, high in the last count of each period |
| cfg_err | output | 1 | Rejected control write flag |

## Verification
The properties assume that up-down counting uses a period of at least 2. They also assume that any compare value used for matching lies inside the period, and that, without shadowing, the period is not lowered below the running count. The stimulus keeps to these limits: it writes period, compares and event selects while the timer is stopped, and the only value it changes mid-run is a shadowed compare. Trigger pulses last one cycle and arrive only in the single-shot modes, so the rule that a trigger is ignored in non-retriggerable mode is checked against a counter that has already started.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_UP   = 2'd2,
        S_DOWN = 2'd3
    } cnt_state_e;

    typedef enum logic [1:0] {
        RUN_CONT   = 2'b00,
        RUN_RETRIG = 2'b01,
        RUN_ONCE   = 2'b10,
        RUN_RSVD   = 2'b11
    } run_mode_e;

    typedef enum logic [1:0] {
        IL_OFF     = 2'b00,
        IL_HALF    = 2'b01,
        IL_THIRD   = 2'b10,
        IL_QUARTER = 2'b11
    } ilv_e;

    // control word, bit 10 down to bit 0
    typedef struct packed {
        logic      upd_only;
        logic      shadow_en;
        ilv_e      ilv;
        logic      pol_b;
        logic      pol_a;
        logic      push_pull;
        run_mode_e mode;
        logic      updown;
        logic      run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int CW   = 16,
    parameter int RW   = 8,
    parameter int NCMP = 4,
    parameter int AW   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [CW-1:0]              wr_data,
    input  logic                       xfer,
    output ctrl_t                      ctrl,
    output logic [CW-1:0]              per_act,
    output logic [NCMP-1:0][CW-1:0]    cmp_eff,
    output logic [RW-1:0]              rep_val,
    output logic [2*(NCMP+1)-1:0]      sel_a,
    output logic [2*(NCMP+1)-1:0]      sel_b,
    output logic                       cfg_err
);
    localparam int EVN = NCMP + 1;

    logic [CW-1:0]           per_sh;
    logic [NCMP-1:0][CW-1:0] cmp_sh, cmp_q;
    logic [CW+1:0]           per_ext;
    ctrl_t                   ctrl_in;
    logic                    ctrl_bad;

    assign ctrl_in  = ctrl_t'(wr_data[CTRL_W-1:0]);
    assign ctrl_bad = ctrl_in.updown && (ctrl_in.ilv != IL_OFF);

    // write-side registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            cfg_err <= 1'b0;
            per_sh  <= '1;
            cmp_sh  <= '0;
            rep_val <= '0;
            sel_a   <= '0;
            sel_b   <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(0)) begin
                if (ctrl_bad) begin
                    cfg_err <= 1'b1;
                end else begin
                    ctrl    <= ctrl_in;
                    cfg_err <= 1'b0;
                end
            end
            if (wr_addr == AW'(1)) per_sh <= wr_data;
            for (int i = 0; i < NCMP; i++) begin
                if (wr_addr == AW'(2 + i)) cmp_sh[i] <= wr_data;
            end
            if (wr_addr == AW'(NCMP + 2)) rep_val <= wr_data[RW-1:0];
            if (wr_addr == AW'(NCMP + 3)) sel_a <= {wr_data[8 +: EVN], wr_data[0 +: EVN]};
            if (wr_addr == AW'(NCMP + 4)) sel_b <= {wr_data[8 +: EVN], wr_data[0 +: EVN]};
        end
    end

    // active registers: direct or shadowed
    always_ff @(posedge clk) begin
        if (rst) begin
            per_act <= '1;
            cmp_q   <= '0;
        end else if (ctrl.shadow_en) begin
            if (xfer) begin
                per_act <= per_sh;
                cmp_q   <= cmp_sh;
            end
        end else if (wr_en) begin
            if (wr_addr == AW'(1)) per_act <= wr_data;
            for (int i = 0; i < NCMP; i++) begin
                if (wr_addr == AW'(2 + i)) cmp_q[i] <= wr_data;
            end
        end
    end

    // interleave forcing of the low compares
    assign per_ext = {2'b00, per_act};

    always_comb begin
        cmp_eff = cmp_q;
        unique case (ctrl.ilv)
            IL_HALF: begin
                cmp_eff[0] = per_act >> 1;
            end
            IL_THIRD: begin
                cmp_eff[0] = CW'(per_ext / 3);
                cmp_eff[1] = CW'((per_ext << 1) / 3);
            end
            IL_QUARTER: begin
                cmp_eff[0] = per_act >> 2;
                cmp_eff[1] = per_act >> 1;
                cmp_eff[2] = CW'((per_ext + (per_ext << 1)) >> 2);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pwmt_core.sv
module pwmt_core
    import pwmt_pkg::*;
#(
    parameter int CW   = 16,
    parameter int RW   = 8,
    parameter int NCMP = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  ctrl_t                   ctrl,
    input  logic [CW-1:0]           per,
    input  logic [NCMP-1:0][CW-1:0] cmp,
    input  logic [RW-1:0]           rep_val,
    input  logic                    trig,
    output cnt_state_e              st,
    output logic [CW-1:0]           cnt,
    output logic [NCMP:0]           ev,
    output logic                    roll,
    output logic                    rep_hit,
    output logic                    xfer
);
    cnt_state_e    st_n;
    logic [CW-1:0] cnt_n;
    logic [RW-1:0] rep_cnt;
    logic          running, top, single, retrig, start;

    assign running = (st == S_UP) || (st == S_DOWN);
    assign top     = (cnt >= per);
    assign single  = (ctrl.mode != RUN_CONT);
    assign retrig  = running && trig && (ctrl.mode == RUN_RETRIG);
    assign start   = ctrl.run && (((st == S_IDLE) && !single) || ((st == S_WAIT) && trig));
    assign roll    = ((st == S_UP) && !ctrl.updown && top) ||
                     ((st == S_DOWN) && (cnt <= CW'(1)));
    assign rep_hit = roll && (rep_cnt == '0);
    assign xfer    = start || retrig || (roll && (!ctrl.upd_only || (rep_cnt == '0)));

    assign ev[0] = (st == S_UP) && (cnt == per);
    for (genvar k = 0; k < NCMP; k++) begin : g_ev
        assign ev[k+1] = running && (cnt == cmp[k]);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // next state and count
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (!ctrl.run) begin
            st_n  = S_IDLE;
            cnt_n = '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    st_n  = single ? S_WAIT : S_UP;
                    cnt_n = '0;
                end
                S_WAIT: begin
                    if (trig) st_n = S_UP;
                    cnt_n = '0;
                end
                S_UP: begin
                    if (retrig) begin
                        cnt_n = '0;
                    end else if (top && ctrl.updown) begin
                        st_n  = S_DOWN;
                        cnt_n = cnt - CW'(1);
                    end else if (top) begin
                        st_n  = single ? S_WAIT : S_UP;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
                S_DOWN: begin
                    if (retrig) begin
                        st_n  = S_UP;
                        cnt_n = '0;
                    end else if (cnt <= CW'(1)) begin
                        st_n  = single ? S_WAIT : S_UP;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt - CW'(1);
                    end
                end
            endcase
        end
    end

    // repetition divider
    always_ff @(posedge clk) begin
        if (rst || !ctrl.run || (st == S_IDLE)) begin
            rep_cnt <= '0;
        end else if (roll) begin
            rep_cnt <= (rep_cnt == '0) ? rep_val : rep_cnt - RW'(1);
        end
    end

endmodule

// File: rtl/pwmt_wave.sv
module pwmt_wave #(
    parameter int EVN = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             down,
    input  logic             roll,
    input  logic             push_pull,
    input  logic             pol_a,
    input  logic             pol_b,
    input  logic [EVN-1:0]   ev,
    input  logic [2*EVN-1:0] sel_a,
    input  logic [2*EVN-1:0] sel_b,
    output logic             pwm_a,
    output logic             pwm_b
);
    logic [1:0]             raw;
    logic [1:0][2*EVN-1:0]  sel;
    logic                   pp_sel;

    assign sel[0] = sel_a;
    assign sel[1] = push_pull ? sel_a : sel_b;

    for (genvar c = 0; c < 2; c++) begin : g_ch
        logic r, set_h, clr_h, up_set, up_clr;
        assign up_set = |(ev & sel[c][EVN-1:0]);
        assign up_clr = |(ev & sel[c][2*EVN-1:EVN]);
        assign set_h  = down ? up_clr : up_set;
        assign clr_h  = down ? up_set : up_clr;

        always_ff @(posedge clk) begin
            if (rst || !run)  r <= 1'b0;
            else if (clr_h)   r <= 1'b0;
            else if (set_h)   r <= 1'b1;
        end
        assign raw[c] = r;
    end

    always_ff @(posedge clk) begin
        if (rst || !run)             pp_sel <= 1'b0;
        else if (roll && push_pull)  pp_sel <= ~pp_sel;
    end

    assign pwm_a = (raw[0] & ~(push_pull &  pp_sel)) ^ pol_a;
    assign pwm_b = (raw[1] & ~(push_pull & ~pp_sel)) ^ pol_b;

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwmt_pkg::*;
#(
    parameter int CW   = 16,
    parameter int RW   = 8,
    parameter int NCMP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          trig,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic          rep_irq,
    output logic          roll_evt,
    output logic          cfg_err
);
    localparam int EVN = NCMP + 1;

    ctrl_t                   ctrl;
    cnt_state_e              st;
    logic [CW-1:0]           per_act, cnt;
    logic [NCMP-1:0][CW-1:0] cmp_eff;
    logic [RW-1:0]           rep_val;
    logic [2*EVN-1:0]        sel_a, sel_b;
    logic [EVN-1:0]          ev;
    logic                    xfer;

    pwmt_regs #(.CW(CW), .RW(RW), .NCMP(NCMP), .AW(4)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .xfer(xfer), .ctrl(ctrl), .per_act(per_act), .cmp_eff(cmp_eff),
        .rep_val(rep_val), .sel_a(sel_a), .sel_b(sel_b), .cfg_err(cfg_err)
    );

    pwmt_core #(.CW(CW), .RW(RW), .NCMP(NCMP)) u_core (
        .clk(clk), .rst(rst), .ctrl(ctrl), .per(per_act), .cmp(cmp_eff),
        .rep_val(rep_val), .trig(trig), .st(st), .cnt(cnt), .ev(ev),
        .roll(roll_evt), .rep_hit(rep_irq), .xfer(xfer)
    );

    pwmt_wave #(.EVN(EVN)) u_wave (
        .clk(clk), .rst(rst), .run(ctrl.run), .down(st == S_DOWN), .roll(roll_evt),
        .push_pull(ctrl.push_pull), .pol_a(ctrl.pol_a), .pol_b(ctrl.pol_b),
        .ev(ev), .sel_a(sel_a), .sel_b(sel_b), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwmt_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input cnt_state_e    st,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] per,
    input ctrl_t         ctrl,
    input logic          trig,
    input logic          wr_en,
    input logic [3:0]    wr_addr,
    input logic [CW-1:0] wr_data,
    input logic          cfg_err,
    input logic          pwm_a,
    input logic          pwm_b,
    input logic          roll_evt,
    input logic          rep_irq
);
    assert_idle_inactive_R1: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> (pwm_a == ctrl.pol_a) && (pwm_b == ctrl.pol_b));

    assert_up_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (st == S_UP && !ctrl.updown && cnt >= per) |=> (cnt == '0));

    assert_turn_down_R4: assert property (@(posedge clk) disable iff (rst)
        (st == S_UP && ctrl.run && ctrl.updown && cnt >= per &&
         !(trig && ctrl.mode == RUN_RETRIG)) |=> (st == S_DOWN));

    assert_once_ignores_trig_R5: assert property (@(posedge clk) disable iff (rst)
        (st == S_UP && ctrl.run && ctrl.mode == RUN_ONCE && cnt < per)
        |=> (cnt == $past(cnt) + CW'(1)));

    assert_pp_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.push_pull && !ctrl.pol_a && !ctrl.pol_b) |-> !(pwm_a && pwm_b));

    assert_irq_on_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        rep_irq |-> roll_evt);

    assert_bad_ctrl_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 4'd0 && wr_data[1] && wr_data[8:7] != 2'b00)
        |=> (cfg_err && $stable(ctrl)));

endmodule

bind pwm_timer pwm_timer_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .st(st), .cnt(cnt), .per(per_act), .ctrl(ctrl),
    .trig(trig), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_err(cfg_err), .pwm_a(pwm_a), .pwm_b(pwm_b), .roll_evt(roll_evt),
    .rep_irq(rep_irq)
);

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        trig = 1'b0;
    logic        pwm_a, pwm_b, rep_irq, roll_evt, cfg_err;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    pwm_timer u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .trig(trig), .pwm_a(pwm_a), .pwm_b(pwm_b), .rep_irq(rep_irq),
        .roll_evt(roll_evt), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = 4'(addr);
        wr_data = 16'(data);
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic stop_timer();
        wr(0, 0);
        repeat (3) tick();
    endtask

    task automatic measure(input int n, output int ha, output int hb, output int hab,
                           output int nr, output int ni);
        ha = 0; hb = 0; hab = 0; nr = 0; ni = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            ha  += int'(pwm_a);
            hb  += int'(pwm_b);
            hab += int'(pwm_a && pwm_b);
            nr  += int'(roll_evt);
            ni  += int'(rep_irq);
        end
    endtask

    task automatic roll_gap(output int g);
        int k = 0;
        while (!roll_evt && k < 300) begin tick(); k++; end
        g = 0;
        do begin tick(); g++; end while (!roll_evt && g < 300);
    endtask

    task automatic t_reset();
        int ha, hb, hab, nr, ni;
        chk("R1 pwm_a after reset", int'(pwm_a), 0);
        chk("R1 pwm_b after reset", int'(pwm_b), 0);
        chk("R12 cfg_err after reset", int'(cfg_err), 0);
        wr(1, 4); wr(2, 1); wr(7, 16'h0201);
        measure(20, ha, hb, hab, nr, ni);
        chk("R1 no wrap while stopped", nr, 0);
        chk("R1 no irq while stopped", ni, 0);
        chk("R1 output held inactive", ha, 0);
    endtask

    task automatic t_up();
        int g, ha, hb, hab, nr, ni;
        stop_timer();
        wr(1, 9); wr(2, 3); wr(7, 16'h0201); wr(8, 16'h0202);
        wr(0, 16'h0001);
        repeat (15) tick();
        roll_gap(g);
        chk("R2 wrap spacing", g, 10);
        measure(10, ha, hb, hab, nr, ni);
        chk("R3 set on period, clear on compare 1", ha, 4);
        measure(20, ha, hb, hab, nr, ni);
        chk("R3 clear wins over set", hb, 0);
    endtask

    task automatic t_pol();
        int ha, hb, hab, nr, ni;
        wr(0, 16'h0061);
        repeat (5) tick();
        measure(10, ha, hb, hab, nr, ni);
        chk("R8 output A inverted", ha, 6);
        chk("R8 output B inverted", hb, 10);
    endtask

    task automatic t_updown();
        int g, ha, hb, hab, nr, ni;
        stop_timer();
        wr(1, 8); wr(2, 3); wr(7, 16'h0002); wr(8, 0);
        wr(0, 16'h0003);
        repeat (20) tick();
        roll_gap(g);
        chk("R4 up-down cycle length", g, 16);
        measure(16, ha, hb, hab, nr, ni);
        chk("R4 set mask clears while descending", ha, 10);
    endtask

    task automatic single_shot(input int ctrl_word, input string req, input int exp_n);
        int n, ha, hb, hab, nr, ni;
        stop_timer();
        wr(1, 9); wr(2, 3); wr(7, 16'h0201);
        wr(0, ctrl_word);
        measure(30, ha, hb, hab, nr, ni);
        chk({req, " waits for trigger"}, nr, 0);
        trig = 1'b1;
        tick();
        trig = 1'b0;
        n = 1;
        while (!roll_evt && n < 50) begin
            if (n == 3) trig = 1'b1;
            tick();
            trig = 1'b0;
            n++;
        end
        chk({req, " samples from trigger to wrap"}, n, exp_n);
        measure(30, ha, hb, hab, nr, ni);
        chk({req, " runs one period only"}, nr, 0);
    endtask

    task automatic t_pushpull();
        int ha, hb, hab, nr, ni;
        stop_timer();
        wr(1, 9); wr(2, 3); wr(7, 16'h0201); wr(8, 0);
        wr(0, 16'h0011);
        repeat (20) tick();
        measure(20, ha, hb, hab, nr, ni);
        chk("R7 output A share", ha, 4);
        chk("R7 output B share", hb, 4);
        chk("R7 never both active", hab, 0);
    endtask

    task automatic t_repeat();
        int ha, hb, hab, nr, ni;
        stop_timer();
        wr(1, 9); wr(6, 2);
        wr(0, 16'h0001);
        repeat (5) tick();
        measure(60, ha, hb, hab, nr, ni);
        chk("R9 wraps in 60 cycles", nr, 6);
        chk("R9 irqs in 60 cycles", ni, 2);
    endtask

    task automatic t_shadow();
        int h, k, ha, hb, hab, nr, ni;
        stop_timer();
        wr(1, 9); wr(2, 3); wr(7, 16'h0201); wr(6, 3);
        wr(0, 16'h0601);
        k = 0;
        while (!rep_irq && k < 200) begin tick(); k++; end
        wr(2, 6);
        h = int'(pwm_a);
        for (int i = 0; i < 9; i++) begin tick(); h += int'(pwm_a); end
        chk("R10 write held in shadow", h, 4);
        measure(10, ha, hb, hab, nr, ni);
        chk("R10 plain wrap does not copy", ha, 4);
        k = 0;
        while (!rep_irq && k < 200) begin tick(); k++; end
        measure(10, ha, hb, hab, nr, ni);
        chk("R10 copied on repetition wrap", ha, 7);
    endtask

    task automatic t_interleave();
        int g, ha, hb, hab, nr, ni;
        stop_timer();
        wr(6, 0); wr(1, 10); wr(2, 3); wr(7, 16'h0201);
        wr(0, 16'h0081);
        repeat (15) tick();
        roll_gap(g);
        measure(11, ha, hb, hab, nr, ni);
        chk("R11 half forces compare 1", ha, 6);
        stop_timer();
        wr(1, 16); wr(3, 1); wr(4, 2); wr(7, 16'h0804);
        wr(0, 16'h0181);
        repeat (20) tick();
        roll_gap(g);
        chk("R11 quarter period unchanged", g, 17);
        measure(17, ha, hb, hab, nr, ni);
        chk("R11 quarter forces compares 2 and 3", ha, 4);
    endtask

    task automatic t_badcfg();
        int g;
        wr(0, 16'h0183);
        chk("R12 error raised", int'(cfg_err), 1);
        roll_gap(g);
        chk("R12 rejected write leaves counting", g, 17);
        wr(0, 16'h0001);
        chk("R12 error cleared", int'(cfg_err), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_up();
        t_pol();
        t_updown();
        single_shot(16'h0009, "R5", 10);
        single_shot(16'h0005, "R6", 13);
        t_pushpull();
        t_repeat();
        t_shadow();
        t_interleave();
        t_badcfg();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule